// File: doc/BRIEF.md
# Programmable Clock Post-Divider with Stepped Low-Power Mode

This block sits behind a synthesizer's oscillator. It divides the fast oscillator clock by 1, 2, 4 or 8, chosen by a 2-bit ratio code, and produces a square output with equal high and low phases. An inverted copy of the output is provided for a differential driver. The block has no streaming data path. Every pin is a plain control or clock pin, and none of them uses a handshake.

A low-power request multiplies the programmed ratio by 16, so the total becomes 16, 32, 64 or 128. The block does not make this change in one jump. It walks through four levels, each of which doubles the period. Each level change waits for a one-cycle pulse from a slower reference timebase. Releasing the request walks the same levels back down, one per pulse. A level change, a new ratio code and a change of the output enable are all applied only where an output period starts. As a result, no high or low phase is ever cut short. While the enable is low, the output rests low and its complement rests high.

Top module: `vco_postdiv`

## Requirements
- R1: The ratio code selects the divide ratio as follows: code 2'b11 gives 1, 2'b00 gives 2, 2'b01 gives 4 and 2'b10 gives 8.
- R2: For every ratio of 2 or more, the high phase and the low phase of the output each last exactly half the divided period, counted in oscillator cycles.
- R3: At ratio 1 (code 2'b11) the enabled output passes the oscillator clock through, giving one output rising edge per oscillator cycle.
- R4: When the enable is low, the output is held low and its complement is held high. Disabling and re-enabling take effect only at the start of an output period, so no high phase shorter than half the period appears.
- R5: While low power is requested, each reference pulse doubles the period, up to four doublings (total ratio = programmed ratio × 16). Further pulses leave the period unchanged.
- R6: After the low-power request is released, each reference pulse halves the period until the programmed ratio is reached again, which takes four pulses from full low power.
- R7: The low-power level changes by at most one step per reference pulse, never without a pulse, and only at an output period start.
- R8: If the request reverses part way through the sequence, the next pulse steps from the current level in the new direction.
- R9: A new ratio code takes effect at the next output period start. The period in progress completes at the old ratio.
- R10: The complement output is always the inverse of the output.
- R11: During reset the output is low and the complement is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | Fast oscillator clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_code | input | 2 | Post-divide ratio select (see R1) |
| lp_req | input | 1 | Low-power request; raises ratio by 16 in steps |
| ref_pulse | input | 1 | One-cycle pacing pulse from the reference timebase |
| out_en | input | 1 | Output enable, applied at period start |
| fout | output | 1 | Divided clock output |
| fout_n | output | 1 | Complement of fout |

## Verification
Each ratio code is exercised with a steady setting, and the measured high and low run lengths tell the four ratios apart and reveal any duty error. Ratio 1 is checked by counting output edges against oscillator edges, because it has no run length to measure. Two kinds of sequence are applied: a full up-and-down low-power walk with one extra pulse at the top, and an interrupted walk that reverses after two steps. Together they separate correct pacing, saturation and reversal from a design that jumps, overshoots or drifts without pulses. Changes of the ratio and the enable are made in the middle of a high phase, which exposes any design that cuts the current period short instead of waiting for its end.

// File: rtl/postdiv_pkg.sv
package postdiv_pkg;
  typedef logic [1:0] ratio_code_t;

  // Code to power-of-two exponent: 11->0, 00->1, 01->2, 10->3
  function automatic logic [1:0] code_to_exp(input ratio_code_t c);
    return 2'(c + 2'd1);
  endfunction
endpackage

// File: rtl/postdiv_lp_step.sv
module postdiv_lp_step #(
  parameter int LP_STEPS = 4,
  localparam int LVL_W = $clog2(LP_STEPS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lp_req,
  input  logic             ref_pulse,
  input  logic             bnd,
  output logic [LVL_W-1:0] lvl_nxt
);
  logic [LVL_W-1:0] lvl_q;
  logic             pend_q;
  logic             want_up, want_dn, want;

  assign want_up = lp_req && (lvl_q < LVL_W'(LP_STEPS));
  assign want_dn = !lp_req && (lvl_q != '0);
  assign want    = want_up || want_dn;

  always_comb begin
    lvl_nxt = lvl_q;
    if (bnd && pend_q) begin
      if (want_up)      lvl_nxt = lvl_q + LVL_W'(1);
      else if (want_dn) lvl_nxt = lvl_q - LVL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      lvl_q <= lvl_nxt;
      if (bnd && pend_q) pend_q <= ref_pulse && want;
      else               pend_q <= pend_q || (ref_pulse && want);
    end
  end

  // R5
  lvl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LVL_W'(LP_STEPS));
  // R7
  lvl_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl_q) |-> $past(bnd && pend_q));
  // R8
  lvl_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q > $past(lvl_q)) |-> $past(lp_req));
endmodule

// File: rtl/postdiv_count.sv
module postdiv_count
  import postdiv_pkg::*;
#(
  parameter int LP_STEPS = 4,
  localparam int LVL_W   = $clog2(LP_STEPS + 1),
  localparam int MAX_EXP = 3 + LP_STEPS,
  localparam int EXP_W   = $clog2(MAX_EXP + 1),
  localparam int CNT_W   = MAX_EXP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ratio_code_t      ratio_code,
  input  logic             out_en,
  input  logic [LVL_W-1:0] lvl_nxt,
  output logic             bnd,
  output logic [EXP_W-1:0] exp_q,
  output logic             tog_q,
  output logic             en_q
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half_m1;
  logic [EXP_W-1:0] new_exp;

  assign half_m1 = (exp_q == '0) ? '0
                 : (CNT_W'(1) << (exp_q - EXP_W'(1))) - CNT_W'(1);
  assign new_exp = EXP_W'(code_to_exp(ratio_code)) + EXP_W'(lvl_nxt);
  assign bnd     = !en_q || (exp_q == '0) || (!tog_q && (cnt_q == half_m1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= EXP_W'(1);
      en_q  <= 1'b0;
      tog_q <= 1'b0;
      cnt_q <= '0;
    end else if (bnd) begin
      exp_q <= new_exp;
      en_q  <= out_en;
      cnt_q <= '0;
      tog_q <= out_en && (new_exp != '0);
    end else if (cnt_q == half_m1) begin
      tog_q <= ~tog_q;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= half_m1);
  // R4
  disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !tog_q);
  // R9
  exp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(exp_q) |-> $past(bnd));
endmodule

// File: rtl/postdiv_outgate.sv
module postdiv_outgate #(
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EXP_W-1:0] exp_q,
  input  logic             tog_q,
  input  logic             en_q,
  output logic             fout,
  output logic             fout_n
);
  logic en_lat;

  // Enable for the pass-through path changes only while the clock is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_lat <= 1'b0;
    else        en_lat <= en_q;
  end

  assign fout   = (exp_q == '0) ? (clk & en_lat) : tog_q;
  assign fout_n = ~fout;
endmodule

// File: rtl/vco_postdiv.sv
module vco_postdiv
  import postdiv_pkg::*;
#(
  parameter int LP_STEPS = 4,
  localparam int LVL_W   = $clog2(LP_STEPS + 1),
  localparam int EXP_W   = $clog2(3 + LP_STEPS + 1)
) (
  input  logic       clk_vco,
  input  logic       rst_n,
  input  logic [1:0] ratio_code,
  input  logic       lp_req,
  input  logic       ref_pulse,
  input  logic       out_en,
  output logic       fout,
  output logic       fout_n
);
  logic             bnd;
  logic [LVL_W-1:0] lvl_nxt;
  logic [EXP_W-1:0] exp_q;
  logic             tog_q, en_q;

  postdiv_lp_step #(.LP_STEPS(LP_STEPS)) u_step (
    .clk(clk_vco), .rst_n(rst_n), .lp_req(lp_req), .ref_pulse(ref_pulse),
    .bnd(bnd), .lvl_nxt(lvl_nxt));

  postdiv_count #(.LP_STEPS(LP_STEPS)) u_count (
    .clk(clk_vco), .rst_n(rst_n), .ratio_code(ratio_code), .out_en(out_en),
    .lvl_nxt(lvl_nxt), .bnd(bnd), .exp_q(exp_q), .tog_q(tog_q), .en_q(en_q));

  postdiv_outgate #(.EXP_W(EXP_W)) u_gate (
    .clk(clk_vco), .rst_n(rst_n), .exp_q(exp_q), .tog_q(tog_q), .en_q(en_q),
    .fout(fout), .fout_n(fout_n));
endmodule

// File: tb/vco_postdiv_bench.sv
module vco_postdiv_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ratio_code = 2'b00;
  logic       lp_req = 1'b0;
  logic       ref_pulse = 1'b0;
  logic       out_en = 1'b1;
  logic       fout, fout_n;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  vco_postdiv u_vco_postdiv (
    .clk_vco(clk), .rst_n(rst_n), .ratio_code(ratio_code), .lp_req(lp_req),
    .ref_pulse(ref_pulse), .out_en(out_en), .fout(fout), .fout_n(fout_n));

  // Run-length monitor and complement monitor, sampled at falling edges
  logic mon_prev = 1'b0;
  int   mon_run  = 0;
  int   min_hi   = 9999;
  int   comp_err = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (fout_n !== ~fout) comp_err++;
      if (fout == mon_prev) mon_run++;
      else begin
        if (mon_prev && mon_run < min_hi) min_hi = mon_run;
        mon_run = 1;
      end
      mon_prev = fout;
    end
  end

  int  p1_edges = 0;
  bit  p1_count = 1'b0;
  always @(posedge fout) if (p1_count) p1_edges++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_ref();
    @(negedge clk); ref_pulse = 1'b1;
    @(negedge clk); ref_pulse = 1'b0;
    cycles(300);
  endtask

  task automatic wait_rise();
    logic p;
    int g = 0;
    @(negedge clk); p = fout;
    forever begin
      @(negedge clk);
      if ((fout && !p) || g > 2000) break;
      p = fout; g++;
    end
  endtask

  task automatic measure(output int hi, output int lo);
    int g = 0;
    wait_rise();
    hi = 1; lo = 0;
    forever begin @(negedge clk); if (!fout || g > 2000) break; hi++; g++; end
    lo = 1;
    forever begin @(negedge clk); if (fout || g > 2000) break; lo++; g++; end
  endtask

  task automatic expect_period(input string req, input int half);
    int hi, lo;
    measure(hi, lo);
    check(hi == half, req, hi, half);
    check(lo == half, req, lo, half);
  endtask

  task automatic t_reset();
    check(fout === 1'b0, "R11", int'(fout), 0);
    check(fout_n === 1'b1, "R11", int'(fout_n), 1);
  endtask

  task automatic t_ratios();
    ratio_code = 2'b00; cycles(20); expect_period("R1 code00", 1);
    ratio_code = 2'b01; cycles(20); expect_period("R1 code01", 2);
    ratio_code = 2'b10; cycles(30); expect_period("R2 code10", 4);
  endtask

  task automatic t_pass();
    ratio_code = 2'b11; cycles(20);
    p1_edges = 0; p1_count = 1'b1;
    cycles(40);
    p1_count = 1'b0;
    check(p1_edges == 40, "R3", p1_edges, 40);
    ratio_code = 2'b00; cycles(20); expect_period("R3 leave", 1);
  endtask

  task automatic t_enable();
    bit stuck = 1'b0;
    ratio_code = 2'b01; cycles(20);
    wait_rise(); min_hi = 9999;
    out_en = 1'b0;
    cycles(30);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (fout !== 1'b0 || fout_n !== 1'b1) stuck = 1'b1;
    end
    check(!stuck, "R4 held", int'(stuck), 0);
    check(min_hi == 2, "R4 no runt off", min_hi, 2);
    out_en = 1'b1; cycles(20);
    expect_period("R4 re-enable", 2);
    check(min_hi == 2, "R4 no runt on", min_hi, 2);
  endtask

  task automatic t_powerdown();
    ratio_code = 2'b10; cycles(30);
    lp_req = 1'b1;
    cycles(400); expect_period("R7 no pulse", 4);
    pulse_ref(); expect_period("R5 step1", 8);
    pulse_ref(); expect_period("R5 step2", 16);
    pulse_ref(); expect_period("R5 step3", 32);
    pulse_ref(); expect_period("R5 step4", 64);
    pulse_ref(); expect_period("R5 saturate", 64);
    lp_req = 1'b0;
    cycles(400); expect_period("R7 hold", 64);
    pulse_ref(); expect_period("R6 step1", 32);
    pulse_ref(); expect_period("R6 step2", 16);
    pulse_ref(); expect_period("R6 step3", 8);
    pulse_ref(); expect_period("R6 step4", 4);
    pulse_ref(); expect_period("R6 floor", 4);
  endtask

  task automatic t_reverse();
    ratio_code = 2'b00; cycles(30);
    lp_req = 1'b1;
    pulse_ref(); pulse_ref();
    expect_period("R8 up2", 4);
    lp_req = 1'b0;
    pulse_ref(); expect_period("R8 reverse", 2);
    pulse_ref(); expect_period("R8 back", 1);
  endtask

  task automatic t_ratio_change();
    int hi, lo;
    int g = 0;
    ratio_code = 2'b10; cycles(30);
    wait_rise();
    ratio_code = 2'b00;
    hi = 1;
    forever begin @(negedge clk); if (!fout || g > 200) break; hi++; g++; end
    lo = 1;
    forever begin @(negedge clk); if (fout || g > 200) break; lo++; g++; end
    check(hi == 4, "R9 old high", hi, 4);
    check(lo == 4, "R9 old low", lo, 4);
    expect_period("R9 new", 1);
  endtask

  initial begin
    cycles(3);
    t_reset();
    rst_n = 1'b1;
    t_ratios();
    t_pass();
    t_enable();
    t_powerdown();
    t_reverse();
    t_ratio_change();
    check(comp_err == 0, "R10", comp_err, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule